// File: doc/BRIEF.md
# Paired Byte Register File

This block keeps six general-purpose byte registers. Each one can be written and read on its own, and they also combine into three 16-bit pairs. A pair is treated as a single word for loads, for stepping up or down by one, for an exchange of two pairs, and for a 16-bit add whose result goes into one of the pairs. Datapath control logic issues one operation per clock through a 3-bit operation code, a byte select and a pair select. Two byte read ports can look at any registers at the same time.

The byte registers are named B, C, D, E, H and L. The pairs are BC, DE and HL. In each pair the first-named register holds the upper byte. Writes take effect on the rising clock edge. The read ports and the carry output are combinational views of the current state.

The add operation puts the sum into HL. It also drives the carry out of bit 15 on a carry output and raises a strobe in the same cycle, so that a flag register elsewhere can capture the carry. No other operation touches the carry. A reset clears every register. The reset input is asserted asynchronously and its release is synchronised inside the block over two clock edges.

Top module: `pairreg_file`

## Requirements
- R1: While reset is held, and after it is released, every byte register reads zero until it is written.
- R2: Operation code 1 writes the 8-bit data input into the register chosen by the byte select: 000=B, 001=C, 010=D, 011=E, 100=H, 101=L. Both read ports return the register chosen by their own 3-bit select with the same encoding, combinationally. Select codes 110 and 111 read as zero and are never written.
- R3: Operation code 2 loads the 16-bit data input into the pair chosen by the pair select (00=BC, 01=DE, 10=HL). The upper byte goes to the first-named register, so loading C0F0h into HL gives H=C0h and L=F0h. A pair select of 11 leaves every register unchanged.
- R4: Operation code 3 adds one to the selected pair, and FFFFh becomes 0000h.
- R5: Operation code 4 subtracts one from the selected pair, and 0000h becomes FFFFh.
- R6: Operation code 5 exchanges the contents of HL and DE in a single cycle and leaves BC unchanged.
- R7: Operation code 6 replaces HL with HL plus the selected pair, modulo 2^16. For example, 4101h plus 0602h gives 4703h. Selecting HL doubles HL, and a pair select of 11 adds zero.
- R8: While operation code 6 is applied, the carry strobe is 1 and the carry output equals bit 16 of the unwrapped sum. Under every other operation code, both outputs are 0. Increment and decrement never raise the carry.
- R9: Operation codes 0 and 7 change no register. Any mix of operations leaves the registers exactly as the rules above dictate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| op_i | input | 3 | Operation code (0 idle, 1 byte write, 2 pair load, 3 increment, 4 decrement, 5 exchange, 6 add, 7 idle) |
| bsel_i | input | 3 | Byte register select for writes |
| psel_i | input | 2 | Pair select |
| wdat8_i | input | 8 | Byte write data |
| wdat16_i | input | 16 | Pair load data |
| rsel_a_i | input | 3 | Byte select of read port A |
| rsel_b_i | input | 3 | Byte select of read port B |
| rdat_a_o | output | 8 | Read port A data |
| rdat_b_o | output | 8 | Read port B data |
| carry_o | output | 1 | Carry out of bit 15 during an add |
| carry_upd_o | output | 1 | High while an add is applied |

## Verification
On every cycle, the checker tracks the whole-pair arithmetic. It confirms that increment and decrement move the chosen pair by exactly one with wrap-around, that the exchange swaps HL and DE, and that the add leaves HL equal to the old HL plus the chosen pair. It also confirms that the reported carry matches whether HL wrapped, that the carry is quiet outside an add, and that idle codes hold all three pairs. Other behaviours can only be shown by the bench's scenarios, where a reference model is compared through the read ports. These are the byte-to-pair aliasing and the upper-byte order, the ignored select codes 110, 111 and pair 11, and reset clearing every register, including reset in the middle of a run.

// File: rtl/pairreg_pkg.sv
package pairreg_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_WRB  = 3'd1,
    OP_LDP  = 3'd2,
    OP_INC  = 3'd3,
    OP_DEC  = 3'd4,
    OP_XCHG = 3'd5,
    OP_ADD  = 3'd6,
    OP_RSV  = 3'd7
  } op_e;

  localparam int NPAIR = 3;
  localparam int NREG  = 2 * NPAIR;
  localparam int BSEL_W = 3;
  localparam int PSEL_W = 2;

  localparam logic [PSEL_W-1:0] PAIR_BC = 2'd0;
  localparam logic [PSEL_W-1:0] PAIR_DE = 2'd1;
  localparam logic [PSEL_W-1:0] PAIR_HL = 2'd2;
endpackage

// File: rtl/pairreg_arith.sv
module pairreg_arith #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] opnd_i,
  input  logic [PW-1:0] hl_i,
  output logic [PW-1:0] inc_o,
  output logic [PW-1:0] dec_o,
  output logic [PW-1:0] sum_o,
  output logic          carry_o
);
  logic [PW:0] wide_sum;

  always_comb begin
    inc_o    = opnd_i + PW'(1);
    dec_o    = opnd_i - PW'(1);
    wide_sum = {1'b0, hl_i} + {1'b0, opnd_i};
    sum_o    = wide_sum[PW-1:0];
    carry_o  = wide_sum[PW];
  end
endmodule

// File: rtl/pairreg_rdport.sv
module pairreg_rdport #(
  parameter int BW   = 8,
  parameter int NR   = 6,
  parameter int SW   = 3
) (
  input  logic [NR*BW-1:0] regs_i,
  input  logic [SW-1:0]    sel_i,
  output logic [BW-1:0]    dat_o
);
  always_comb begin
    dat_o = '0;
    for (int i = 0; i < NR; i++) begin
      if (sel_i == SW'(i)) dat_o = regs_i[i*BW +: BW];
    end
  end
endmodule

// File: rtl/pairreg_bank.sv
module pairreg_bank
  import pairreg_pkg::*;
#(
  parameter int BW = 8,
  localparam int PW = 2 * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_i,
  input  logic [BSEL_W-1:0] bsel_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic [BW-1:0]     wd8_i,
  input  logic [PW-1:0]     wd16_i,
  input  logic [PW-1:0]     inc_i,
  input  logic [PW-1:0]     dec_i,
  input  logic [PW-1:0]     sum_i,
  input  logic [PW-1:0]     de_i,
  input  logic [PW-1:0]     hl_i,
  output logic [NREG*BW-1:0] regs_o
);
  logic [PW-1:0] word_nxt;
  logic          word_op;

  always_comb begin
    word_op  = 1'b1;
    word_nxt = wd16_i;
    case (op_i)
      OP_LDP:  word_nxt = wd16_i;
      OP_INC:  word_nxt = inc_i;
      OP_DEC:  word_nxt = dec_i;
      default: word_op  = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int  P  = i / 2;
    localparam bit  HI = (i % 2) == 0;
    logic          byte_hit;
    logic          pair_hit;
    logic [PW-1:0] pair_val;
    logic          en;
    logic [BW-1:0] d;
    logic [BW-1:0] q;

    always_comb begin
      byte_hit = (op_i == OP_WRB) && (bsel_i == BSEL_W'(i));
      pair_hit = 1'b0;
      pair_val = word_nxt;
      if (word_op && (psel_i == PSEL_W'(P))) begin
        pair_hit = 1'b1;
      end else if ((op_i == OP_ADD) && (PSEL_W'(P) == PAIR_HL)) begin
        pair_hit = 1'b1;
        pair_val = sum_i;
      end else if ((op_i == OP_XCHG) && (PSEL_W'(P) == PAIR_HL)) begin
        pair_hit = 1'b1;
        pair_val = de_i;
      end else if ((op_i == OP_XCHG) && (PSEL_W'(P) == PAIR_DE)) begin
        pair_hit = 1'b1;
        pair_val = hl_i;
      end
      en = byte_hit | pair_hit;
      if (byte_hit)  d = wd8_i;
      else if (HI)   d = pair_val[PW-1:BW];
      else           d = pair_val[BW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign regs_o[i*BW +: BW] = q;
  end
endmodule

// File: rtl/pairreg_file.sv
module pairreg_file
  import pairreg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [2:0]        bsel_i,
  input  logic [1:0]        psel_i,
  input  logic [BYTE_W-1:0] wdat8_i,
  input  logic [2*BYTE_W-1:0] wdat16_i,
  input  logic [2:0]        rsel_a_i,
  input  logic [2:0]        rsel_b_i,
  output logic [BYTE_W-1:0] rdat_a_o,
  output logic [BYTE_W-1:0] rdat_b_o,
  output logic              carry_o,
  output logic              carry_upd_o
);
  localparam int PW = 2 * BYTE_W;

  logic [1:0]             rst_sync;
  logic                   rst_core_n;
  op_e                    op;
  logic [NREG*BYTE_W-1:0] regs;
  logic [PW-1:0]          pair_bc, pair_de, pair_hl, pair_sel;
  logic [PW-1:0]          inc_v, dec_v, sum_v;
  logic                   add_cy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign op = op_e'(op_i);

  assign pair_bc = {regs[0*BYTE_W +: BYTE_W], regs[1*BYTE_W +: BYTE_W]};
  assign pair_de = {regs[2*BYTE_W +: BYTE_W], regs[3*BYTE_W +: BYTE_W]};
  assign pair_hl = {regs[4*BYTE_W +: BYTE_W], regs[5*BYTE_W +: BYTE_W]};

  always_comb begin
    case (psel_i)
      PAIR_BC: pair_sel = pair_bc;
      PAIR_DE: pair_sel = pair_de;
      PAIR_HL: pair_sel = pair_hl;
      default: pair_sel = '0;
    endcase
  end

  pairreg_arith #(.PW(PW)) u_arith (
    .opnd_i  (pair_sel),
    .hl_i    (pair_hl),
    .inc_o   (inc_v),
    .dec_o   (dec_v),
    .sum_o   (sum_v),
    .carry_o (add_cy)
  );

  pairreg_bank #(.BW(BYTE_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .op_i   (op),
    .bsel_i (bsel_i),
    .psel_i (psel_i),
    .wd8_i  (wdat8_i),
    .wd16_i (wdat16_i),
    .inc_i  (inc_v),
    .dec_i  (dec_v),
    .sum_i  (sum_v),
    .de_i   (pair_de),
    .hl_i   (pair_hl),
    .regs_o (regs)
  );

  logic [2:0]        rsel [2];
  logic [BYTE_W-1:0] rdat [2];
  assign rsel[0] = rsel_a_i;
  assign rsel[1] = rsel_b_i;

  for (genvar k = 0; k < 2; k++) begin : g_rd
    pairreg_rdport #(.BW(BYTE_W), .NR(NREG), .SW(BSEL_W)) u_rd (
      .regs_i (regs),
      .sel_i  (rsel[k]),
      .dat_o  (rdat[k])
    );
  end
  assign rdat_a_o = rdat[0];
  assign rdat_b_o = rdat[1];

  assign carry_upd_o = (op == OP_ADD);
  assign carry_o     = carry_upd_o & add_cy;
endmodule

// File: rtl/pairreg_file_chk.sv
module pairreg_file_chk #(
  parameter int BW = 8,
  localparam int PW = 2 * BW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op,
  input logic [1:0]    psel,
  input logic [PW-1:0] bc,
  input logic [PW-1:0] de,
  input logic [PW-1:0] hl,
  input logic          carry_o,
  input logic          carry_upd_o
);
  function automatic logic [PW-1:0] pick(logic [1:0] s, logic [PW-1:0] a,
                                         logic [PW-1:0] b, logic [PW-1:0] c);
    case (s)
      2'd0:    return a;
      2'd1:    return b;
      2'd2:    return c;
      default: return '0;
    endcase
  endfunction

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3 && psel != 2'd3) |=>
      pick($past(psel), bc, de, hl) == PW'($past(pick(psel, bc, de, hl)) + PW'(1))); // R4

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4 && psel != 2'd3) |=>
      pick($past(psel), bc, de, hl) == PW'($past(pick(psel, bc, de, hl)) - PW'(1))); // R5

  AST_XCHG_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5) |=> (hl == $past(de)) && (de == $past(hl)) && $stable(bc)); // R6

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd6) |=> hl == PW'($past(hl) + $past(pick(psel, bc, de, hl)))); // R7

  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd6) |=> $past(carry_o) == (hl < $past(hl))); // R8

  AST_CARRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 3'd6) |-> (!carry_o && !carry_upd_o)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 || op == 3'd7) |=> ($stable(bc) && $stable(de) && $stable(hl))); // R9
endmodule

bind pairreg_file pairreg_file_chk #(.BW(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .op          (op_i),
  .psel        (psel_i),
  .bc          (pair_bc),
  .de          (pair_de),
  .hl          (pair_hl),
  .carry_o     (carry_o),
  .carry_upd_o (carry_upd_o)
);

// File: tb/pairreg_file_test.sv
module pairreg_file_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = '0, bsel_i = '0, rsel_a_i = '0, rsel_b_i = '0;
  logic [1:0]  psel_i = '0;
  logic [7:0]  wdat8_i = '0;
  logic [15:0] wdat16_i = '0;
  logic [7:0]  rdat_a_o, rdat_b_o;
  logic        carry_o, carry_upd_o;

  int m [6];
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pairreg_file uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .bsel_i(bsel_i), .psel_i(psel_i),
    .wdat8_i(wdat8_i), .wdat16_i(wdat16_i), .rsel_a_i(rsel_a_i), .rsel_b_i(rsel_b_i),
    .rdat_a_o(rdat_a_o), .rdat_b_o(rdat_b_o), .carry_o(carry_o), .carry_upd_o(carry_upd_o)
  );

  function automatic int rd(int s);
    return (s < 6) ? m[s] : 0;
  endfunction

  function automatic int pr(int p);
    return (p < 3) ? ((m[2*p] << 8) | m[2*p+1]) : 0;
  endfunction

  function automatic void setp(int p, int v);
    m[2*p]   = (v >> 8) & 255;
    m[2*p+1] = v & 255;
  endfunction

  task automatic step(input int op, input int bs, input int ps, input int d8,
                      input int d16, input int ra, input int rb, input string tag);
    int sum, ecy, eupd;
    bit bad;
    @(negedge clk);
    op_i = 3'(op); bsel_i = 3'(bs); psel_i = 2'(ps);
    wdat8_i = 8'(d8); wdat16_i = 16'(d16); rsel_a_i = 3'(ra); rsel_b_i = 3'(rb);
    #1;
    sum  = pr(ps) + pr(2);
    eupd = (op == 6) ? 1 : 0;
    ecy  = (op == 6) ? ((sum >> 16) & 1) : 0;
    bad  = 1'b0;
    nvec++;
    if (int'(rdat_a_o) != rd(ra)) begin
      bad = 1'b1;
      $display("FAIL %s read A sel %0d: got %02h expected %02h", tag, ra, rdat_a_o, rd(ra));
    end
    if (int'(rdat_b_o) != rd(rb)) begin
      bad = 1'b1;
      $display("FAIL %s read B sel %0d: got %02h expected %02h", tag, rb, rdat_b_o, rd(rb));
    end
    if (int'(carry_o) != ecy || int'(carry_upd_o) != eupd) begin
      bad = 1'b1;
      $display("FAIL %s carry/strobe: got %0b/%0b expected %0d/%0d", tag, carry_o,
               carry_upd_o, ecy, eupd);
    end
    if (bad) nbad++;
    @(posedge clk);
    case (op)
      1: if (bs < 6) m[bs] = d8 & 255;
      2: if (ps < 3) setp(ps, d16 & 65535);
      3: if (ps < 3) setp(ps, (pr(ps) + 1) & 65535);
      4: if (ps < 3) setp(ps, (pr(ps) + 65535) & 65535);
      5: begin
        int t;
        t = pr(1);
        setp(1, pr(2));
        setp(2, t);
      end
      6: setp(2, sum & 65535);
      default: ;
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_i = '0;
    for (int i = 0; i < 6; i++) m[i] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    step(0, 0, 0, 8'h5A, 16'h1234, 0, 1, tag);
    step(0, 0, 0, 8'h5A, 16'h1234, 2, 3, tag);
    step(0, 0, 0, 8'h5A, 16'h1234, 4, 5, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    do_reset();
    read_all("R1");

    // R2: byte writes and readback, including unused select codes
    step(1, 0, 0, 8'h11, 0, 0, 1, "R2");
    step(1, 1, 0, 8'h22, 0, 0, 1, "R2");
    step(1, 2, 0, 8'h33, 0, 0, 1, "R2");
    step(1, 3, 0, 8'h44, 0, 2, 3, "R2");
    step(1, 4, 0, 8'h55, 0, 3, 4, "R2");
    step(1, 5, 0, 8'h66, 0, 4, 5, "R2");
    step(1, 6, 0, 8'hAA, 0, 5, 0, "R2");
    step(1, 7, 0, 8'hBB, 0, 6, 7, "R2");
    step(0, 0, 0, 0, 0, 6, 7, "R2");
    read_all("R2");

    // R3: pair load byte order, select 11 ignored
    step(2, 0, 2, 0, 16'hC0F0, 4, 5, "R3");
    step(2, 0, 0, 0, 16'h0102, 4, 5, "R3");
    step(2, 0, 3, 0, 16'h9999, 0, 1, "R3");
    read_all("R3");

    // R4 / R5: wrap
    step(2, 0, 1, 0, 16'hFFFF, 2, 3, "R4");
    step(3, 0, 1, 0, 0, 2, 3, "R4");
    step(3, 0, 3, 0, 0, 2, 3, "R4");
    read_all("R4");
    step(2, 0, 0, 0, 16'h0000, 0, 1, "R5");
    step(4, 0, 0, 0, 0, 0, 1, "R5");
    step(4, 0, 2, 0, 0, 0, 1, "R5");
    read_all("R5");

    // R6: exchange
    step(2, 0, 2, 0, 16'h4101, 4, 5, "R6");
    step(2, 0, 1, 0, 16'h0602, 2, 3, "R6");
    step(5, 0, 0, 0, 0, 2, 4, "R6");
    read_all("R6");
    step(5, 0, 0, 0, 0, 3, 5, "R6");

    // R7 / R8: add without and with carry
    step(6, 0, 1, 0, 0, 4, 5, "R8");
    step(0, 0, 0, 0, 0, 4, 5, "R7");
    step(2, 0, 2, 0, 16'hF000, 4, 5, "R8");
    step(2, 0, 0, 0, 16'h2000, 0, 1, "R8");
    step(6, 0, 0, 0, 0, 4, 5, "R8");
    step(6, 0, 2, 0, 0, 4, 5, "R7");
    step(6, 0, 3, 0, 0, 4, 5, "R7");
    step(2, 0, 2, 0, 16'h8000, 4, 5, "R8");
    step(6, 0, 2, 0, 0, 4, 5, "R8");
    read_all("R7");

    // R9: idle codes hold state
    step(7, 2, 1, 8'hEE, 16'hEEEE, 0, 1, "R9");
    step(0, 3, 2, 8'hDD, 16'hDDDD, 2, 3, "R9");
    read_all("R9");

    for (int n = 0; n < 400; n++) begin
      step($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom_range(0, 255), $urandom_range(0, 65535),
           $urandom_range(0, 7), $urandom_range(0, 7), "R9");
    end

    do_reset();
    read_all("R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule